// File: doc/BRIEF.md
# Three-Phase Space-Vector Gate Pulse Generator

This block produces the six gate signals of a two-level, three-leg inverter from a sector number and two active-vector on-times. Inside it a symmetric up/down carrier runs from zero to a programmable peak and back. Three compare levels are derived from the on-times: a common zero-vector offset, that offset plus half the first on-time, and that offset plus half the summed on-times. The carrier is compared against these levels. The comparison pattern is the same in every sector. The sector only decides which leg receives which level, so each carrier period walks 000 → one leg high → two legs high → 111 and then back down.

Sector, on-times and carrier peak are sampled only at the instant the carrier sits at zero, so a period never mixes old and new values. Each leg then passes through a dead-band stage. That stage holds back the turn-on of the upper and the lower switch by a programmable number of cycles and drops any on-pulse that is too short to survive the delay.

Top module: `svpwm_gate_gen`

## Requirements
- R1: While `rst` is high, all six gate outputs are low.
- R2: With carrier peak P (`half_period_in`), one carrier period lasts 2P cycles. The carrier counts 0,1,…,P,P-1,…,1 and then wraps. A leg assigned compare level k is driven high for every cycle with carrier ≥ k, which is 2(P-k)+1 cycles per period for 1 ≤ k ≤ P, all 2P cycles for k = 0, and none for k > P.
- R3: With L = 2P, Tx' = min(Tx, L), S = min(Tx+Ty, L) and Z = floor((L-S)/4), the levels are Z for the leading leg, Z + floor(Tx'/2) for the middle leg and Z + floor(S/2) for the trailing leg. Leading/middle/trailing legs per sector code (`sector_in`): 1 = a/b/c, 2 = b/a/c, 3 = b/c/a, 4 = c/b/a, 5 = c/a/b, 6 = a/c/b. Leg a is bit 0, leg b is bit 1, leg c is bit 2 of both gate buses.
- R4: Sector codes 0 and 7 drive no upper switch. Every lower switch stays on.
- R5: When Tx+Ty exceeds 2P, the summed on-time is clamped to 2P, so the leading leg stays on for the whole period.
- R6: With zero dead time and distinct, non-zero spacing between levels, the upper outputs change in at most one leg per cycle.
- R7: A dead time of D cycles (`dead_in`) shortens every upper and every lower on-interval of a leg by D cycles.
- R8: An on-interval of D cycles or fewer produces no pulse at all on that switch.
- R9: The upper and lower output of a leg are never high in the same cycle.
- R10: Levels, sector and carrier peak change only in the cycle right after the carrier was at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_in | input | 3 | Sector code 1..6; 0 and 7 mean no active vector |
| tx_in | input | CW | On-time of the one-leg-high vector, in carrier cycles |
| ty_in | input | CW | On-time of the two-legs-high vector, in carrier cycles |
| half_period_in | input | CW | Carrier peak P; switching period is 2P cycles |
| dead_in | input | DTW | Dead time in cycles |
| gate_hi | output | 3 | Upper switch gates, bit 0 = leg a |
| gate_lo | output | 3 | Lower switch gates, bit 0 = leg a |

## Verification
A new setting takes effect at the next carrier zero, which may be up to 2P cycles away. After that the compare result goes through the dead-band sample register and the output register, adding two more cycles. The dead-band run counter needs up to 2^DTW cycles to saturate on a leg that no longer toggles. The bench therefore holds each setting for 6P+100 cycles before it measures anything. It then counts high cycles on every output over one window of exactly 2P cycles. Because the count does not depend on where the window starts within the period, the checks never need to know the carrier phase.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

    // Position of a leg in the switching sequence of a sector
    typedef enum logic [1:0] {
        RANK_LEAD  = 2'd0,
        RANK_MID   = 2'd1,
        RANK_TRAIL = 2'd2,
        RANK_OFF   = 2'd3
    } leg_rank_e;

    localparam int unsigned NUM_LEGS = 3;

    // Rank of one leg (0 = a, 1 = b, 2 = c) for a given sector code
    function automatic leg_rank_e leg_rank(input logic [2:0] sector, input int unsigned leg);
        leg_rank_e ra, rb, rc;
        case (sector)
            3'd1: begin ra = RANK_LEAD;  rb = RANK_MID;   rc = RANK_TRAIL; end
            3'd2: begin ra = RANK_MID;   rb = RANK_LEAD;  rc = RANK_TRAIL; end
            3'd3: begin ra = RANK_TRAIL; rb = RANK_LEAD;  rc = RANK_MID;   end
            3'd4: begin ra = RANK_TRAIL; rb = RANK_MID;   rc = RANK_LEAD;  end
            3'd5: begin ra = RANK_MID;   rb = RANK_TRAIL; rc = RANK_LEAD;  end
            3'd6: begin ra = RANK_LEAD;  rb = RANK_TRAIL; rc = RANK_MID;   end
            default: begin ra = RANK_OFF; rb = RANK_OFF; rc = RANK_OFF; end
        endcase
        case (leg)
            0:       return ra;
            1:       return rb;
            default: return rc;
        endcase
    endfunction

endpackage

// File: rtl/svpwm_carrier.sv
module svpwm_carrier #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] half_period_in,
    output logic [CW-1:0] carrier,
    output logic [CW-1:0] peak,
    output logic          at_zero
);
    logic          up_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] peak_q;

    assign at_zero = (cnt_q == '0);
    assign carrier = cnt_q;
    assign peak    = peak_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            peak_q <= '0;
            up_q   <= 1'b1;
        end else if (at_zero) begin
            peak_q <= half_period_in;
            up_q   <= 1'b1;
            cnt_q  <= (half_period_in == '0) ? '0 : CW'(1);
        end else if (up_q) begin
            if (cnt_q >= peak_q) begin
                cnt_q <= cnt_q - CW'(1);
                up_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/svpwm_threshold.sv
module svpwm_threshold #(
    parameter int CW = 12,
    localparam int KW = CW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [2:0]          sector_in,
    input  logic [CW-1:0]       tx_in,
    input  logic [CW-1:0]       ty_in,
    input  logic [CW-1:0]       half_period_in,
    output logic [2:0][KW-1:0]  level_q,
    output logic [2:0]          sector_q
);
    logic [KW-1:0]      lim, txc, sum_raw, sum_c, zero_off;
    logic [2:0][KW-1:0] level_d;

    always_comb begin
        lim      = {half_period_in, 1'b0};
        txc      = ({1'b0, tx_in} > lim) ? lim : {1'b0, tx_in};
        sum_raw  = {1'b0, tx_in} + {1'b0, ty_in};
        sum_c    = (sum_raw > lim) ? lim : sum_raw;
        zero_off = (lim - sum_c) >> 2;
        level_d[0] = zero_off;
        level_d[1] = zero_off + (txc >> 1);
        level_d[2] = zero_off + (sum_c >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            sector_q <= '0;
        end else if (load) begin
            level_q  <= level_d;
            sector_q <= sector_in;
        end
    end
endmodule

// File: rtl/svpwm_deadband.sv
module svpwm_deadband #(
    parameter int DTW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           leg_on,
    input  logic [DTW-1:0] dead_in,
    output logic           hi,
    output logic           lo
);
    logic           s_q;
    logic [DTW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q   <= 1'b0;
            run_q <= '0;
            hi    <= 1'b0;
            lo    <= 1'b0;
        end else begin
            s_q <= leg_on;
            if (leg_on != s_q)
                run_q <= '0;
            else if (run_q != '1)
                run_q <= run_q + DTW'(1);
            hi <= s_q  && (run_q >= dead_in);
            lo <= !s_q && (run_q >= dead_in);
        end
    end
endmodule

// File: rtl/svpwm_gate_gen.sv
module svpwm_gate_gen
    import svpwm_pkg::*;
#(
    parameter int CW  = 12,
    parameter int DTW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     sector_in,
    input  logic [CW-1:0]  tx_in,
    input  logic [CW-1:0]  ty_in,
    input  logic [CW-1:0]  half_period_in,
    input  logic [DTW-1:0] dead_in,
    output logic [2:0]     gate_hi,
    output logic [2:0]     gate_lo
);
    localparam int KW = CW + 1;

    logic [CW-1:0]      carrier;
    logic [CW-1:0]      peak;
    logic               at_zero;
    logic [2:0][KW-1:0] level_q;
    logic [2:0]         sector_q;
    logic [2:0]         leg_on;

    svpwm_carrier #(.CW(CW)) u_car (
        .clk            (clk),
        .rst            (rst),
        .half_period_in (half_period_in),
        .carrier        (carrier),
        .peak           (peak),
        .at_zero        (at_zero)
    );

    svpwm_threshold #(.CW(CW)) u_thr (
        .clk            (clk),
        .rst            (rst),
        .load           (at_zero),
        .sector_in      (sector_in),
        .tx_in          (tx_in),
        .ty_in          (ty_in),
        .half_period_in (half_period_in),
        .level_q        (level_q),
        .sector_q       (sector_q)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        leg_rank_e rank;
        always_comb begin
            rank = leg_rank(sector_q, g);
            if (rank == RANK_OFF)
                leg_on[g] = 1'b0;
            else
                leg_on[g] = ({1'b0, carrier} >= level_q[rank]);
        end

        svpwm_deadband #(.DTW(DTW)) u_db (
            .clk     (clk),
            .rst     (rst),
            .leg_on  (leg_on[g]),
            .dead_in (dead_in),
            .hi      (gate_hi[g]),
            .lo      (gate_lo[g])
        );
    end
endmodule

// File: rtl/svpwm_gate_chk.sv
module svpwm_gate_chk #(
    parameter int CW = 12,
    parameter int LW = 3 * (CW + 1) + 3
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    gate_hi,
    input logic [2:0]    gate_lo,
    input logic [CW-1:0] carrier,
    input logic [CW-1:0] peak,
    input logic          at_zero,
    input logic [LW-1:0] lat_word
);
    // R1: reset holds every gate low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

    // R9: never both switches of one leg
    assert_no_shoot_through_R9: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == 3'b000);

    // R2: carrier never passes its latched peak
    assert_carrier_bound_R2: assert property (@(posedge clk) disable iff (rst)
        carrier <= peak);

    // R2: a running carrier moves every cycle
    assert_carrier_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (peak != '0) |-> (carrier != $past(carrier)));

    // R10: sampled settings change only after a carrier zero
    assert_latch_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(at_zero) |-> ($stable(lat_word) && $stable(peak)));
endmodule

bind svpwm_gate_gen svpwm_gate_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .carrier  (carrier),
    .peak     (peak),
    .at_zero  (at_zero),
    .lat_word ({level_q, sector_q})
);

// File: tb/svpwm_gate_gen_tb.sv
module svpwm_gate_gen_tb;
    localparam int CW  = 12;
    localparam int DTW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     sector_in = '0;
    logic [CW-1:0]  tx_in = '0;
    logic [CW-1:0]  ty_in = '0;
    logic [CW-1:0]  half_period_in = CW'(16);
    logic [DTW-1:0] dead_in = '0;
    logic [2:0]     gate_hi;
    logic [2:0]     gate_lo;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    svpwm_gate_gen #(.CW(CW), .DTW(DTW)) u_dut (
        .clk(clk), .rst(rst), .sector_in(sector_in), .tx_in(tx_in), .ty_in(ty_in),
        .half_period_in(half_period_in), .dead_in(dead_in),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic check(input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    // R3 sector table: 0 lead, 1 middle, 2 trailing, 3 off
    function automatic int exp_rank(input int sec, input int leg);
        int r [3];
        case (sec)
            1: r = '{0, 1, 2};
            2: r = '{1, 0, 2};
            3: r = '{2, 0, 1};
            4: r = '{2, 1, 0};
            5: r = '{1, 2, 0};
            6: r = '{0, 2, 1};
            default: r = '{3, 3, 3};
        endcase
        return r[leg];
    endfunction

    // R2/R3/R5: on-cycles per period for a leg before dead time
    function automatic int exp_width(input int sec, input int leg, input int tx, input int ty, input int per);
        int lim, txc, s, z, k, rk;
        rk = exp_rank(sec, leg);
        if (rk == 3) return 0;
        lim = 2 * per;
        txc = (tx > lim) ? lim : tx;
        s   = (tx + ty > lim) ? lim : tx + ty;
        z   = (lim - s) / 4;
        k   = z + ((rk == 0) ? 0 : (rk == 1) ? txc / 2 : s / 2);
        if (k == 0) return lim;
        if (k > per) return 0;
        return 2 * (per - k) + 1;
    endfunction

    task automatic run_case(input int sec, input int tx, input int ty, input int per,
                            input int dt, input string tag, input bit chk_seq);
        int hi_cnt [3];
        int lo_cnt [3];
        int multi;
        logic [2:0] prev;
        @(negedge clk);
        sector_in      = 3'(sec);
        tx_in          = CW'(tx);
        ty_in          = CW'(ty);
        half_period_in = CW'(per);
        dead_in        = DTW'(dt);
        repeat (6 * per + 100) @(negedge clk);
        hi_cnt = '{0, 0, 0};
        lo_cnt = '{0, 0, 0};
        multi  = 0;
        prev   = gate_hi;
        for (int n = 0; n < 2 * per; n++) begin
            for (int l = 0; l < 3; l++) begin
                hi_cnt[l] += int'(gate_hi[l]);
                lo_cnt[l] += int'(gate_lo[l]);
            end
            if ($countones(gate_hi ^ prev) > 1) multi++;
            prev = gate_hi;
            @(negedge clk);
        end
        for (int l = 0; l < 3; l++) begin
            int w, eh, el;
            w = exp_width(sec, l, tx, ty, per);
            if (w == 2 * per)      begin eh = w; el = 0; end
            else if (w == 0)       begin eh = 0; el = 2 * per; end
            else begin
                eh = (w > dt) ? w - dt : 0;
                el = (2 * per - w > dt) ? 2 * per - w - dt : 0;
            end
            check($sformatf("%s sec %0d leg %0d upper count", tag, sec, l), hi_cnt[l], eh);
            check($sformatf("%s sec %0d leg %0d lower count", tag, sec, l), lo_cnt[l], el);
        end
        if (chk_seq)
            check($sformatf("R6 sec %0d multi-leg changes", sec), multi, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1 reset upper", int'(gate_hi), 0);
            check("R1 reset lower", int'(gate_lo), 0);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2, R3, R6: every sector, no dead time
        for (int s = 1; s <= 6; s++)
            run_case(s, 20, 30, 40, 0, "R2 R3", 1'b1);
        // R4: invalid sector codes
        run_case(0, 20, 30, 40, 0, "R4", 1'b0);
        run_case(7, 20, 30, 40, 0, "R4", 1'b0);
        // R5: on-time sum beyond the period
        run_case(2, 30, 30, 20, 0, "R5", 1'b0);
        run_case(5, 100, 3, 20, 2, "R5", 1'b0);
        // R7: dead time shortens both switches
        run_case(3, 20, 30, 40, 5, "R7", 1'b0);
        // R8: one-cycle low interval vanishes under dead time 3
        run_case(1, 40, 34, 40, 3, "R8", 1'b0);

        // random settings
        for (int i = 0; i < 24; i++) begin
            int per, tx, ty, s, dt;
            per = 8 + int'($urandom % 50);
            s   = int'($urandom % 8);
            tx  = int'($urandom % (per + 10));
            ty  = int'($urandom % (per + 10));
            dt  = int'($urandom % 5);
            run_case(s, tx, ty, per, dt, "R2 R3 R7 random", 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule